// File: doc/BRIEF.md
# DMA Burst Length Controller

This block turns the programmable burst settings of a DMA engine into the burst limits that the transmit and receive channels actually use. A programmed beat count is first optionally scaled by eight. A zero is raised to one beat, and the result is capped at a ceiling derived from the FIFO size. The receive channel either follows the transmit field or takes its own field, depending on a select flag. For each channel the block also reports the largest bus burst length that is both enabled and no larger than that channel's limit.

The block also decides whether the transmit DMA may launch a burst in the current cycle. It may launch when the transmit FIFO has room for a whole burst, or when the frame ends sooner than one full burst. All outputs are registered, so a configuration or status change appears at the outputs one clock later. The FIFOs and descriptor fetching belong to neighbouring blocks.

Top module: `dma_burst_ctrl`

## Requirements
- R1: A programmed burst field of zero gives an effective burst of one beat, with or without the x8 flag.
- R2: With the x8 flag clear and the field between 1 and the ceiling, the effective burst equals the field value in beats.
- R3: With the x8 flag set, the effective burst is eight times the field value, subject to R4.
- R4: The effective burst never exceeds the ceiling of (FIFO_BYTES / 2) / 4 words, which is 256 for the default 2048-byte FIFO. A larger request yields exactly the ceiling.
- R5: When `rx_sep_en` is 1, the receive burst is derived from `rx_pbl`. When it is 0, the receive burst is derived from `tx_pbl` and equals the transmit burst.
- R6: Bit i of `bus_len_en` enables a bus burst of 4·2^i beats. Each channel's bus length output is the largest enabled length that does not exceed its effective burst, or 1 if no such length exists. For example, burst 32 with 16 enabled gives 16, and burst 8 with 16 and 8 enabled gives 8.
- R7: `tx_start` is 1 when `tx_fifo_free` (in words) is at least the effective transmit burst.
- R8: `tx_start` is also 1 when `tx_bytes_left` is less than the effective transmit burst times 4 bytes. It is 0 when neither this condition nor the R7 condition holds.
- R9: Every output reflects the inputs sampled at the previous rising clock edge.
- R10: While `rst` is high, both bursts and both bus lengths read 1 and `tx_start` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pbl | input | PBL_W | Transmit (or shared) programmed burst field |
| rx_pbl | input | PBL_W | Receive programmed burst field |
| x8_en | input | 1 | Multiply programmed fields by eight |
| rx_sep_en | input | 1 | Receive uses its own field |
| bus_len_en | input | NLEN | Enabled bus burst lengths, bit i = 4·2^i beats |
| tx_fifo_free | input | FREE_W | Free transmit FIFO space in words |
| tx_bytes_left | input | LEFT_W | Bytes left to end of the current frame |
| tx_burst | output | LIM_W | Effective transmit burst in beats |
| rx_burst | output | LIM_W | Effective receive burst in beats |
| tx_bus_len | output | LIM_W | Largest permitted bus burst for transmit |
| rx_bus_len | output | LIM_W | Largest permitted bus burst for receive |
| tx_start | output | 1 | Transmit burst may start |

## Verification
The bench builds the block with its defaults: a 6-bit burst field, a 2048-byte FIFO and three bus lengths (4, 8, 16). These values make the whole field range sweepable against every bus-length mask, with both x8 settings and both receive-select settings. Because 63·8 exceeds 256, the cap is reached and tested from both sides. A second sweep varies free space and bytes-left across the threshold for several burst sizes, so the start decision is checked on both edges of each condition.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BUS_BASE   = 4;

  function automatic int burst_ceiling(input int fifo_bytes);
    return (fifo_bytes / 2) / WORD_BYTES;
  endfunction
endpackage

// File: rtl/dbc_scale.sv
module dbc_scale
  import dbc_pkg::*;
#(
  parameter int PBL_W   = 6,
  parameter int MAX_LIM = 256,
  parameter int LIM_W   = 9
) (
  input  logic [PBL_W-1:0] pbl,
  input  logic             x8,
  output logic [LIM_W-1:0] burst
);
  localparam int RAW_W = PBL_W + 3;

  logic [RAW_W-1:0] raw;

  always_comb begin
    raw = x8 ? {pbl, 3'b000} : RAW_W'(pbl);
    if (raw == '0)
      burst = LIM_W'(1);
    else if (int'(raw) > MAX_LIM)
      burst = LIM_W'(MAX_LIM);
    else
      burst = LIM_W'(raw);
  end
endmodule

// File: rtl/dbc_bus_pick.sv
module dbc_bus_pick
  import dbc_pkg::*;
#(
  parameter int NLEN  = 3,
  parameter int LIM_W = 9
) (
  input  logic [NLEN-1:0]  len_en,
  input  logic [LIM_W-1:0] limit,
  output logic [LIM_W-1:0] bus_len
);
  logic [LIM_W-1:0] cand [NLEN];

  for (genvar i = 0; i < NLEN; i++) begin : g_len
    localparam int LEN = BUS_BASE << i;
    assign cand[i] = (len_en[i] && (LEN <= int'(limit))) ? LIM_W'(LEN) : '0;
  end

  always_comb begin
    bus_len = LIM_W'(1);
    for (int i = 0; i < NLEN; i++)
      if (cand[i] != '0) bus_len = cand[i];
  end
endmodule

// File: rtl/dbc_tx_gate.sv
module dbc_tx_gate
  import dbc_pkg::*;
#(
  parameter int LIM_W  = 9,
  parameter int FREE_W = 10,
  parameter int LEFT_W = 16
) (
  input  logic [LIM_W-1:0]  burst,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic [LEFT_W-1:0] bytes_left,
  output logic              start
);
  int unsigned need_bytes;
  logic room_ok, tail_ok;

  always_comb begin
    need_bytes = int'(burst) * WORD_BYTES;
    room_ok    = int'(fifo_free) >= int'(burst);
    tail_ok    = int'(bytes_left) < need_bytes;
    start      = room_ok || tail_ok;
  end
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dbc_pkg::*;
#(
  parameter int PBL_W      = 6,
  parameter int FIFO_BYTES = 2048,
  parameter int NLEN       = 3,
  parameter int LEFT_W     = 16,
  localparam int MAX_LIM   = burst_ceiling(FIFO_BYTES),
  localparam int LIM_W     = $clog2(MAX_LIM + 1),
  localparam int FREE_W    = $clog2(FIFO_BYTES / WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PBL_W-1:0]  tx_pbl,
  input  logic [PBL_W-1:0]  rx_pbl,
  input  logic              x8_en,
  input  logic              rx_sep_en,
  input  logic [NLEN-1:0]   bus_len_en,
  input  logic [FREE_W-1:0] tx_fifo_free,
  input  logic [LEFT_W-1:0] tx_bytes_left,
  output logic [LIM_W-1:0]  tx_burst,
  output logic [LIM_W-1:0]  rx_burst,
  output logic [LIM_W-1:0]  tx_bus_len,
  output logic [LIM_W-1:0]  rx_bus_len,
  output logic              tx_start
);
  logic [PBL_W-1:0] rx_field;
  logic [LIM_W-1:0] tx_b_d, rx_b_d, tx_bl_d, rx_bl_d;
  logic             start_d;

  assign rx_field = rx_sep_en ? rx_pbl : tx_pbl;

  dbc_scale #(.PBL_W(PBL_W), .MAX_LIM(MAX_LIM), .LIM_W(LIM_W)) u_tx_scale (
    .pbl(tx_pbl), .x8(x8_en), .burst(tx_b_d));

  dbc_scale #(.PBL_W(PBL_W), .MAX_LIM(MAX_LIM), .LIM_W(LIM_W)) u_rx_scale (
    .pbl(rx_field), .x8(x8_en), .burst(rx_b_d));

  dbc_bus_pick #(.NLEN(NLEN), .LIM_W(LIM_W)) u_tx_pick (
    .len_en(bus_len_en), .limit(tx_b_d), .bus_len(tx_bl_d));

  dbc_bus_pick #(.NLEN(NLEN), .LIM_W(LIM_W)) u_rx_pick (
    .len_en(bus_len_en), .limit(rx_b_d), .bus_len(rx_bl_d));

  dbc_tx_gate #(.LIM_W(LIM_W), .FREE_W(FREE_W), .LEFT_W(LEFT_W)) u_gate (
    .burst(tx_b_d), .fifo_free(tx_fifo_free), .bytes_left(tx_bytes_left),
    .start(start_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_burst   <= LIM_W'(1);
      rx_burst   <= LIM_W'(1);
      tx_bus_len <= LIM_W'(1);
      rx_bus_len <= LIM_W'(1);
      tx_start   <= 1'b0;
    end else begin
      tx_burst   <= tx_b_d;
      rx_burst   <= rx_b_d;
      tx_bus_len <= tx_bl_d;
      rx_bus_len <= rx_bl_d;
      tx_start   <= start_d;
    end
  end

  // R4 and R1: effective burst stays within 1 .. ceiling
  a_r4_burst_range: assert property (@(posedge clk) disable iff (rst)
    (tx_burst != '0) && (int'(tx_burst) <= MAX_LIM) && (rx_burst != '0) && (int'(rx_burst) <= MAX_LIM));

  // R6: bus length is a single power of two no larger than the channel burst
  a_r6_bus_fits: assert property (@(posedge clk) disable iff (rst)
    ($countones(tx_bus_len) == 1) && (tx_bus_len <= tx_burst) &&
    ($countones(rx_bus_len) == 1) && (rx_bus_len <= rx_burst));

  // R5: shared field makes both channels equal one cycle later
  a_r5_shared: assert property (@(posedge clk) disable iff (rst)
    !rx_sep_en |=> (rx_burst == tx_burst));

  // R7, R8: start decision follows last cycle's status against the new burst
  a_r8_start_rule: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tx_start == ((int'($past(tx_fifo_free)) >= int'(tx_burst)) ||
                           (int'($past(tx_bytes_left)) < int'(tx_burst) * WORD_BYTES))));

  // R9: stable configuration keeps burst outputs stable
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(tx_pbl) && $stable(x8_en)) |=> $stable(tx_burst));
endmodule

// File: tb/dma_burst_ctrl_tb.sv
module dma_burst_ctrl_tb;
  localparam int PBL_W = 6;
  localparam int NLEN  = 3;
  localparam int CEIL  = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  tx_pbl, rx_pbl;
  logic        x8_en, rx_sep_en;
  logic [2:0]  bus_len_en;
  logic [9:0]  tx_fifo_free;
  logic [15:0] tx_bytes_left;
  logic [8:0]  tx_burst, rx_burst, tx_bus_len, rx_bus_len;
  logic        tx_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_burst_ctrl u_dut (
    .clk(clk), .rst(rst), .tx_pbl(tx_pbl), .rx_pbl(rx_pbl), .x8_en(x8_en),
    .rx_sep_en(rx_sep_en), .bus_len_en(bus_len_en), .tx_fifo_free(tx_fifo_free),
    .tx_bytes_left(tx_bytes_left), .tx_burst(tx_burst), .rx_burst(rx_burst),
    .tx_bus_len(tx_bus_len), .rx_bus_len(rx_bus_len), .tx_start(tx_start));

  function automatic int exp_burst(input int f, input bit m);
    int v = m ? f * 8 : f;
    if (v == 0) return 1;
    if (v > CEIL) return CEIL;
    return v;
  endfunction

  function automatic int exp_bus(input int lim, input int en);
    int r = 1;
    for (int i = 0; i < NLEN; i++)
      if (en[i] && (4 << i) <= lim) r = 4 << i;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tx_pbl = 6'd20; rx_pbl = 6'd3; x8_en = 1'b1; rx_sep_en = 1'b1;
    bus_len_en = 3'b111; tx_fifo_free = 10'd0; tx_bytes_left = 16'd0;
    step; step;
    // R10: reset values
    chk("R10 tx_burst", tx_burst, 1);
    chk("R10 rx_burst", rx_burst, 1);
    chk("R10 tx_bus_len", tx_bus_len, 1);
    chk("R10 rx_bus_len", rx_bus_len, 1);
    chk("R10 tx_start", tx_start, 0);
    rst = 1'b0;
    tx_bytes_left = 16'hFFFF;

    // R1..R6 sweep: every field, both x8, both select, every mask
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int en = 0; en < 8; en++)
          for (int f = 0; f < 64; f++) begin
            int et, er;
            tx_pbl = 6'(f); rx_pbl = 6'(63 - f); x8_en = m[0];
            rx_sep_en = s[0]; bus_len_en = 3'(en);
            step;
            et = exp_burst(f, m[0]);
            er = s ? exp_burst(63 - f, m[0]) : et;
            if (f == 0) chk("R1 zero field", tx_burst, 1);
            else if (!m[0]) chk("R2 plain burst", tx_burst, et);
            else if (f * 8 > CEIL) chk("R4 cap", tx_burst, CEIL);
            else chk("R3 x8 burst", tx_burst, et);
            chk("R5 rx burst", rx_burst, er);
            chk("R6 tx bus len", tx_bus_len, exp_bus(et, en));
            chk("R6 rx bus len", rx_bus_len, exp_bus(er, en));
          end

    // R6 named examples
    x8_en = 1'b0; rx_sep_en = 1'b0; tx_pbl = 6'd32; bus_len_en = 3'b100; step;
    chk("R6 32 with 16", tx_bus_len, 16);
    tx_pbl = 6'd8; bus_len_en = 3'b110; step;
    chk("R6 8 with 16,8", tx_bus_len, 8);
    x8_en = 1'b1; tx_pbl = 6'd32; step;
    chk("R4 exact ceiling", tx_burst, 256);

    // R7, R8 sweep over free space and bytes left
    x8_en = 1'b0;
    foreach (tx_pbl[i]) ;
    for (int b = 1; b <= 40; b += 13) begin
      tx_pbl = 6'(b);
      for (int fr = 0; fr < 48; fr += 3)
        for (int bl = 0; bl < 200; bl += 7) begin
          bit ex;
          tx_fifo_free = 10'(fr); tx_bytes_left = 16'(bl);
          step;
          ex = (fr >= b) || (bl < b * 4);
          if (fr >= b) chk("R7 room start", tx_start, ex);
          else chk("R8 tail start", tx_start, ex);
        end
    end
    // R7/R8 exact edges, burst 16
    tx_pbl = 6'd16; tx_bytes_left = 16'd64;
    tx_fifo_free = 10'd15; step; chk("R8 no start at edge", tx_start, 0);
    tx_fifo_free = 10'd16; step; chk("R7 start exact room", tx_start, 1);
    tx_fifo_free = 10'd15; tx_bytes_left = 16'd63; step;
    chk("R8 start short tail", tx_start, 1);

    // R9: one-cycle latency
    tx_pbl = 6'd5; step;
    tx_pbl = 6'd9;
    @(posedge clk); #1;
    chk("R9 new value after one edge", tx_burst, 9);
    tx_pbl = 6'd12; #1;
    chk("R9 holds before edge", tx_burst, 9);
    @(negedge clk);

    // R10: reset mid-run
    rst = 1'b1; step;
    chk("R10 reset again", tx_burst, 1);
    chk("R10 start low", tx_start, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule